// File: doc/BRIEF.md
# Flash Converter Thermometer Cleanup and Binary Encoder

This block sits behind the comparator bank of a flash converter. Each sample arrives as an N-bit word that should be a thermometer code: ones filling the low bits up to some level and zeros above. Comparator offsets and noise can flip single bits, and such a flipped bit is called a bubble. The block repairs every isolated wrong bit with a three-input majority vote over each bit and its two neighbours. It then encodes the cleaned word as a binary level.

The pipeline has two register stages, one after the vote and one after the encoder. A sample presented with `in_valid` high appears on the outputs two clock edges later, with `out_valid` high. The cleaned word is also sent out. A flag reports when the vote could not restore a legal thermometer code, which happens with runs of two or more wrong bits. A downstream user can discard or count such samples.

Top module: `flash_thermo_fixer`

## Requirements
- R1: Corrected bit i equals the majority of raw bits i-1, i and i+1, for every interior bit.
- R2: For bit 0 the missing lower neighbour counts as 1, so a raw word with only bit 0 low and all other bits high is corrected to all ones.
- R3: For bit N-1 the missing upper neighbour counts as 0, so a raw word with only bit N-1 high is corrected to all zeros.
- R4: Any single isolated flipped bit (first-order bubble) in an otherwise legal thermometer word is removed, and the corrected word is a legal thermometer code.
- R5: `out_code` equals the number of consecutive ones in the corrected word counted upward from bit 0. It ranges from 0 to N and is clog2(N+1) bits wide.
- R6: `out_bad` is 1 exactly when the corrected word has some bit i at 0 and bit i+1 at 1.
- R7: `out_valid` is high in the cycle two rising edges after a cycle in which `in_valid` was high, and low otherwise.
- R8: A synchronous reset (`rst` high at a rising edge) clears `out_valid`, `out_word`, `out_code` and `out_bad` to zero.
- R9: While `in_valid` is low, the result registers hold the last result, so `out_word`, `out_code` and `out_bad` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Raw comparator word is present this cycle |
| in_word | input | N | Raw comparator outputs, bit 0 is the lowest threshold |
| out_valid | output | 1 | Result registers hold a new sample |
| out_word | output | N | Word after the majority vote |
| out_code | output | clog2(N+1) | Binary level, count of low-end ones |
| out_bad | output | 1 | Corrected word is still not a thermometer code |

## Verification
The hardest condition to reach from the ports is a corrected word that is still illegal. A first-order bubble never produces one, so the stimulus uses raw words with two-bit wrong runs, for example alternating pairs. These pass the vote unchanged, and the bench checks that the flag is raised. The two word ends are a second awkward case. The stimulus flips only the lowest bit of a full word and only the highest bit of an empty word, so each result depends on the assumed value of the missing neighbour.

// File: rtl/flash_thermo_pkg.sv
package flash_thermo_pkg;

    // three-input majority vote
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/thermo_vote_stage.sv
module thermo_vote_stage
    import flash_thermo_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [N-1:0] raw,
    output logic         vld_q,
    output logic [N-1:0] word_q
);
    // raw word padded with the assumed neighbours: 1 below bit 0, 0 above bit N-1
    logic [N+1:0] padded;
    logic [N-1:0] voted;

    assign padded = {1'b0, raw, 1'b1};

    for (genvar gi = 0; gi < N; gi++) begin : g_vote
        assign voted[gi] = vote3(padded[gi], padded[gi+1], padded[gi+2]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            word_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                word_q <= voted;
            end
        end
    end
endmodule

// File: rtl/thermo_count_stage.sv
module thermo_count_stage #(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [N-1:0]  word,
    output logic          out_valid,
    output logic [N-1:0]  out_word,
    output logic [CW-1:0] out_code,
    output logic          out_bad
);
    logic [CW-1:0] run_len;
    logic          hit_zero;
    logic          rise_seen;

    // length of the low-end run of ones
    always_comb begin
        run_len  = '0;
        hit_zero = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!word[i]) begin
                hit_zero = 1'b1;
            end else if (!hit_zero) begin
                run_len = run_len + {{(CW-1){1'b0}}, 1'b1};
            end
        end
    end

    // any 0 followed by a 1 higher up marks an illegal code
    always_comb begin
        rise_seen = 1'b0;
        for (int i = 0; i < N - 1; i++) begin
            if (!word[i] && word[i+1]) begin
                rise_seen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_code  <= '0;
            out_bad   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= word;
                out_code <= run_len;
                out_bad  <= rise_seen;
            end
        end
    end
endmodule

// File: rtl/flash_thermo_fixer.sv
module flash_thermo_fixer #(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [N-1:0]  in_word,
    output logic          out_valid,
    output logic [N-1:0]  out_word,
    output logic [CW-1:0] out_code,
    output logic          out_bad
);
    logic         mid_vld;
    logic [N-1:0] mid_word;

    thermo_vote_stage #(.N(N)) u_vote (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .raw     (in_word),
        .vld_q   (mid_vld),
        .word_q  (mid_word)
    );

    thermo_count_stage #(.N(N), .CW(CW)) u_count (
        .clk      (clk),
        .rst      (rst),
        .in_valid (mid_vld),
        .word     (mid_word),
        .out_valid(out_valid),
        .out_word (out_word),
        .out_code (out_code),
        .out_bad  (out_bad)
    );
endmodule

// File: rtl/flash_thermo_fixer_chk.sv
module flash_thermo_fixer_chk #(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          out_valid,
    input logic [N-1:0]  out_word,
    input logic [CW-1:0] out_code,
    input logic          out_bad
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    // R7: valid travels through exactly two stages
    a_r7_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R8: first cycle after reset shows cleared outputs
    a_r8_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_word == '0 && out_code == '0 && !out_bad));

    // R5: level never exceeds N
    a_r5_code_range: assert property (@(posedge clk) disable iff (rst)
        out_code <= CW'(N));

    // R5/R6: a legal word is exactly the low-end run of ones
    a_r6_legal_matches_code: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_bad) |-> (out_word == N'((({(N+1){1'b0}} | 1'b1) << out_code) - 1'b1)));

    // R6: an illegal word cannot be all ones
    a_r6_bad_not_full: assert property (@(posedge clk) disable iff (rst)
        out_bad |-> (out_code < CW'(N)));

    // R9: no new sample, result registers stay put
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && !out_valid) |-> ($stable(out_word) && $stable(out_code) && $stable(out_bad)));
endmodule

bind flash_thermo_fixer flash_thermo_fixer_chk #(.N(N), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_word (out_word),
    .out_code (out_code),
    .out_bad  (out_bad)
);

// File: tb/flash_thermo_fixer_tb.sv
module flash_thermo_fixer_tb;
    localparam int N      = 8;
    localparam int CW     = 4;
    localparam int CLK_NS = 10;
    localparam int NV     = 13;

    // {raw, expected word, expected code, expected flag}
    localparam logic [20:0] VEC [NV] = '{
        {8'h00, 8'h00, 4'd0, 1'b0},
        {8'hFF, 8'hFF, 4'd8, 1'b0},
        {8'h3F, 8'h3F, 4'd6, 1'b0},
        {8'h5F, 8'h3F, 4'd6, 1'b0},
        {8'h02, 8'h01, 4'd1, 1'b0},
        {8'hF7, 8'hFF, 4'd8, 1'b0},
        {8'h08, 8'h00, 4'd0, 1'b0},
        {8'h33, 8'h33, 4'd2, 1'b1},
        {8'hFE, 8'hFF, 4'd8, 1'b0},
        {8'h7F, 8'h7F, 4'd7, 1'b0},
        {8'h80, 8'h00, 4'd0, 1'b0},
        {8'hCF, 8'hCF, 4'd4, 1'b1},
        {8'h01, 8'h01, 4'd1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [N-1:0]  in_word = '0;
    logic          out_valid;
    logic [N-1:0]  out_word;
    logic [CW-1:0] out_code;
    logic          out_bad;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    flash_thermo_fixer #(.N(N)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_word(out_word), .out_code(out_code), .out_bad(out_bad)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // one sample, outputs read two edges later
    task automatic send(input logic [N-1:0] w);
        @(negedge clk);
        in_word  = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 not yet valid", 32'(out_valid), 32'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 valid", 32'(out_valid), 32'd0);
        check("R8 word", 32'(out_word), 32'd0);
        check("R8 code", 32'(out_code), 32'd0);
        check("R8 flag", 32'(out_bad), 32'd0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            send(VEC[k][20:13]);
            check("R7 valid after two edges", 32'(out_valid), 32'd1);
            check("R1/R2/R3/R4 word", 32'(out_word), 32'(VEC[k][12:5]));
            check("R5 code", 32'(out_code), 32'(VEC[k][4:1]));
            check("R6 flag", 32'(out_bad), 32'(VEC[k][0]));
        end

        // R9: idle cycles keep the last result (0x01 -> 1)
        @(negedge clk);
        in_word = 8'hFF;
        repeat (3) @(negedge clk);
        check("R9 valid low", 32'(out_valid), 32'd0);
        check("R9 word held", 32'(out_word), 32'h01);
        check("R9 code held", 32'(out_code), 32'd1);

        // R7: back-to-back samples stream one per cycle
        @(negedge clk);
        in_word = 8'h0F; in_valid = 1'b1;
        @(negedge clk);
        in_word = 8'h33;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 first of pair valid", 32'(out_valid), 32'd1);
        check("R5 first of pair code", 32'(out_code), 32'd4);
        @(negedge clk);
        check("R6 second of pair flag", 32'(out_bad), 32'd1);
        check("R5 second of pair code", 32'(out_code), 32'd2);
        @(negedge clk);
        check("R7 valid drops", 32'(out_valid), 32'd0);

        // R8: reset after a result clears it
        send(8'hFF);
        rst = 1'b1;
        @(negedge clk);
        check("R8 word cleared", 32'(out_word), 32'd0);
        check("R8 code cleared", 32'(out_code), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule